// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns instruction-fetch virtual addresses into physical addresses. A single last-page register sits in front of a 64-slot fully associative translation table. A fetch that stays in the page it used last is answered in the same cycle. A fetch to a new page costs one stall cycle while the table is searched. On a table hit, the last-page register is loaded from the result.

When the table misses, the block raises a miss flag and shows the faulting virtual page number. It then waits for a software handler to write the translation through the fill port, and retries the lookup on the next cycle. Table slots can map 8 KB, 64 KB, 512 KB or 4 MB pages. The fetch unit must hold its request stable for as long as the stall output is high.

Top module: `itlb_xlate`

## Requirements
- R1: After reset, no response, stall or miss is reported until a fetch arrives, and the last-page register and every table slot are empty.
- R2: A fetch whose bits [31:13] equal the page held in the last-page register gets `resp_valid` in the same cycle with no stall. `resp_paddr` is the held physical page followed by the fetch address bits [12:0].
- R3: A fetch to a different page holds `stall` high for exactly one cycle. On a table hit, the response follows in the next cycle.
- R4: A table hit loads the last-page register with the 8 KB page of the fetch and its physical page, so a later fetch in that page does not stall.
- R5: `fill_size` codes 0, 1, 2 and 3 map 8 KB, 64 KB, 512 KB and 4 MB pages. They leave the low 0, 3, 6 and 9 page-number bits out of the compare and copy those bits from the virtual page into the physical page.
- R6: On a table miss, `miss` and `stall` stay high and `miss_vpn` holds the faulting page until a fill is accepted.
- R7: The retried lookup answers in the cycle after the fill cycle.
- R8: Fills go to slots in round-robin order, so the 65th fill overwrites the oldest of the previous 64.
- R9: `inval_all` empties the table and the last-page register, and a fill in the same cycle is dropped.
- R10: When several table slots match a page, the lowest-numbered slot supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request, held while stall is high |
| req_vaddr | input | VA_W | Fetch virtual address |
| stall | output | 1 | Request cannot be answered this cycle |
| resp_valid | output | 1 | Translation valid this cycle |
| resp_paddr | output | PA_W | Translated physical address |
| miss | output | 1 | Table miss waiting for a software fill |
| miss_vpn | output | VA_W-13 | Faulting virtual page number |
| fill_valid | input | 1 | Write one table slot |
| fill_vpn | input | VA_W-13 | Virtual page of the fill |
| fill_ppn | input | PA_W-13 | Physical page of the fill |
| fill_size | input | 2 | Page-size code of the fill |
| inval_all | input | 1 | Empty the table and the last-page register |

## Verification
The bound checker watches these rules on every cycle:
- A fetch that does not stall is answered at once.
- A single stall on a page change leads either to a response or to a miss.
- A miss keeps stall high and keeps its page number until a fill arrives.
- A matching fill brings the response one cycle later.
- After a flush, the next fetch stalls.

Some behaviour only the bench scenarios can show: the physical address under each page-size code, the lowest-slot pick between overlapping slots, the round-robin eviction after 64 fills, and a fill being dropped when it meets a flush.

// File: rtl/itlb_xlate.sv
module itlb_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 64,
  parameter int PG_BITS = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    stall,
  output logic                    resp_valid,
  output logic [PA_W-1:0]         resp_paddr,
  output logic                    miss,
  output logic [VA_W-PG_BITS-1:0] miss_vpn,
  input  logic                    fill_valid,
  input  logic [VA_W-PG_BITS-1:0] fill_vpn,
  input  logic [PA_W-PG_BITS-1:0] fill_ppn,
  input  logic [1:0]              fill_size,
  input  logic                    inval_all
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PPN_W = PA_W - PG_BITS;
  localparam int IDX_W = $clog2(ENTRIES);

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_MISS} state_t;
  state_t st;

  logic [VPN_W-1:0]   t_vpn [ENTRIES];
  logic [PPN_W-1:0]   t_ppn [ENTRIES];
  logic [1:0]         t_sz  [ENTRIES];
  logic [ENTRIES-1:0] t_vld;
  logic [IDX_W-1:0]   ptr;

  logic             u_vld;
  logic [VPN_W-1:0] u_vpn;
  logic [PPN_W-1:0] u_ppn;
  logic [VPN_W-1:0] pend_vpn;

  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  logic             u_hit;

  assign u_hit = u_vld && (u_vpn == req_vaddr[VA_W-1:PG_BITS]);

  always_comb begin
    logic [8:0] lo;
    hit     = 1'b0;
    hit_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      lo = 9'((1 << (3 * int'(t_sz[i]))) - 1);
      if (t_vld[i] && (((pend_vpn ^ t_vpn[i]) & ~{{(VPN_W-9){1'b0}}, lo}) == '0)) begin
        hit     = 1'b1;
        hit_ppn = (t_ppn[i] & ~{{(PPN_W-9){1'b0}}, lo}) |
                  {{(PPN_W-9){1'b0}}, pend_vpn[8:0] & lo};
      end
    end
  end

  assign resp_valid = (st == S_IDLE && req_valid && u_hit) || (st == S_SEARCH && hit);
  assign resp_paddr = {(st == S_SEARCH) ? hit_ppn : u_ppn, req_vaddr[PG_BITS-1:0]};
  assign miss       = (st == S_MISS) || (st == S_SEARCH && !hit);
  assign stall      = (st == S_IDLE && req_valid && !u_hit) || miss;
  assign miss_vpn   = pend_vpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend_vpn <= '0;
      u_vld    <= 1'b0;
      t_vld    <= '0;
      ptr      <= '0;
    end else begin
      case (st)
        S_IDLE:   if (req_valid && !u_hit) begin
                    pend_vpn <= req_vaddr[VA_W-1:PG_BITS];
                    st       <= S_SEARCH;
                  end
        S_SEARCH: st <= hit ? S_IDLE : S_MISS;
        S_MISS:   if (fill_valid && !inval_all) st <= S_SEARCH;
        default:  st <= S_IDLE;
      endcase
      if (st == S_SEARCH && hit) u_vld <= 1'b1;
      if (inval_all) begin
        u_vld <= 1'b0;
        t_vld <= '0;
      end else if (fill_valid) begin
        t_vld[ptr] <= 1'b1;
        ptr        <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_SEARCH && hit) begin
      u_vpn <= pend_vpn;
      u_ppn <= hit_ppn;
    end
    if (fill_valid && !inval_all) begin
      t_vpn[ptr] <= fill_vpn;
      t_ppn[ptr] <= fill_ppn;
      t_sz[ptr]  <= fill_size;
    end
  end
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
  parameter int VPN_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             stall,
  input logic             resp_valid,
  input logic             miss,
  input logic [VPN_W-1:0] miss_vpn,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [1:0]       fill_size,
  input logic             inval_all
);
  AST_NO_STALL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !stall |-> resp_valid); // R2
  AST_ONE_SEARCH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !miss |=> resp_valid || miss); // R3
  AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> stall && !resp_valid); // R6
  AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    miss && !fill_valid |=> miss && $stable(miss_vpn)); // R6
  AST_FILL_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    miss && fill_valid && !inval_all && fill_vpn == miss_vpn && fill_size == 2'd0
    |=> resp_valid && !stall); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all && !stall |=> (req_valid |-> stall)); // R9
endmodule

bind itlb_xlate itlb_xlate_chk #(.VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .stall(stall),
  .resp_valid(resp_valid), .miss(miss), .miss_vpn(miss_vpn),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_size(fill_size),
  .inval_all(inval_all)
);

// File: tb/itlb_xlate_bench.sv
module itlb_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        stall, resp_valid, miss;
  logic [31:0] resp_paddr;
  logic [18:0] miss_vpn;
  logic        fill_valid = 1'b0;
  logic [18:0] fill_vpn = '0;
  logic [18:0] fill_ppn = '0;
  logic [1:0]  fill_size = '0;
  logic        inval_all = 1'b0;
  bit          done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  itlb_xlate u_itlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .stall(stall), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .miss(miss), .miss_vpn(miss_vpn), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size),
    .inval_all(inval_all)
  );

  function automatic logic [31:0] va(input logic [18:0] pg, input logic [12:0] off);
    return {pg, off};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected response", resp_paddr, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(resp_paddr == e, t, resp_paddr, e);
      end
    end
  end

  task automatic fill(input logic [18:0] v, input logic [18:0] p, input logic [1:0] sz, input bit inv);
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_size = sz; inval_all = inv;
    @(posedge clk); #1;
    fill_valid = 1'b0; inval_all = 1'b0;
  endtask

  task automatic flush();
    @(posedge clk); #1; inval_all = 1'b1;
    @(posedge clk); #1; inval_all = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [31:0] pa, input int stalls, input string tag);
    int n;
    exp_q.push_back(pa); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = a;
    n = 0;
    forever begin
      @(negedge clk);
      if (resp_valid || miss || n > 4) break;
      n++;
    end
    check(n == stalls && !miss, {tag, " stall count"}, n, stalls);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic fetch_miss(input logic [31:0] a, input logic [18:0] p, input logic [31:0] pa, input string tag);
    int n;
    exp_q.push_back(pa); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = a;
    n = 0;
    forever begin
      @(negedge clk);
      if (resp_valid || miss || n > 4) break;
      n++;
    end
    check(miss == 1'b1, {tag, " R6 miss raised"}, miss, 1);
    check(miss_vpn == a[31:13], {tag, " R6 miss page"}, miss_vpn, a[31:13]);
    @(posedge clk); #1;
    @(negedge clk);
    check(miss && stall && !resp_valid, {tag, " R6 miss held"}, {miss, stall, resp_valid}, 3'b110);
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_vpn = a[31:13]; fill_ppn = p; fill_size = 2'd0;
    @(negedge clk);
    check(stall && !resp_valid, {tag, " R6 stall in fill cycle"}, {stall, resp_valid}, 2'b10);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk);
    check(resp_valid && !stall, {tag, " R7 retry answers"}, {resp_valid, stall}, 2'b10);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!stall && !resp_valid && !miss, "R1 reset outputs", {stall, resp_valid, miss}, 3'b000);

    // R6 R7: empty table misses, fill resolves
    fetch_miss(va(19'h10, 13'h123), 19'h777, va(19'h777, 13'h123), "R6 first fetch");
    // R2 R4: same page answered at once
    fetch(va(19'h10, 13'h1F0), va(19'h777, 13'h1F0), 0, "R2 same page");
    fill(19'h20, 19'h888, 2'd0, 1'b0);
    fetch(va(19'h20, 13'h004), va(19'h888, 13'h004), 1, "R3 page crossing");
    fetch(va(19'h20, 13'h008), va(19'h888, 13'h008), 0, "R4 reloaded page");
    fetch(va(19'h10, 13'h000), va(19'h777, 13'h000), 1, "R3 cross back");

    // R5 page sizes
    fill(19'h100, 19'h3F0, 2'd1, 1'b0);
    fetch(va(19'h105, 13'h011), va(19'h3F5, 13'h011), 1, "R5 64K page");
    fill(19'h4000, 19'h1234, 2'd2, 1'b0);
    fetch(va(19'h4027, 13'h0A0), va(19'h1227, 13'h0A0), 1, "R5 512K page");
    fill(19'h20000, 19'h5555, 2'd3, 1'b0);
    fetch(va(19'h201AB, 13'h1FFF), va(19'h55AB, 13'h1FFF), 1, "R5 4M page");
    fetch_miss(va(19'h108, 13'h000), 19'h999, va(19'h999, 13'h000), "R5 outside 64K page");

    // R10 overlapping slots
    fill(19'h3003, 19'h111, 2'd0, 1'b0);
    fill(19'h3000, 19'h222, 2'd1, 1'b0);
    fetch(va(19'h3003, 13'h040), va(19'h111, 13'h040), 1, "R10 lowest slot");
    fetch(va(19'h3005, 13'h000), va(19'h225, 13'h000), 1, "R10 single match");

    // R9 flush
    fetch(va(19'h3005, 13'h010), va(19'h225, 13'h010), 0, "R9 before flush");
    flush();
    fetch_miss(va(19'h3005, 13'h000), 19'hABC, va(19'hABC, 13'h000), "R9 after flush");
    fill(19'h50, 19'h555, 2'd0, 1'b1);
    fetch_miss(va(19'h50, 13'h000), 19'h556, va(19'h556, 13'h000), "R9 fill dropped");

    // R8 round robin
    flush();
    for (int i = 0; i < 64; i++) fill(19'h1000 + 19'(i), 19'h2000 + 19'(i), 2'd0, 1'b0);
    fetch(va(19'h1000, 13'h000), va(19'h2000, 13'h000), 1, "R8 first of 64");
    fetch(va(19'h103F, 13'h000), va(19'h203F, 13'h000), 1, "R8 last of 64");
    fill(19'h7000, 19'h7777, 2'd0, 1'b0);
    fetch(va(19'h7000, 13'h002), va(19'h7777, 13'h002), 1, "R8 new fill");
    fetch(va(19'h1001, 13'h000), va(19'h2001, 13'h000), 1, "R8 second oldest kept");
    fetch_miss(va(19'h1000, 13'h000), 19'h2ABC, va(19'h2ABC, 13'h000), "R8 oldest evicted");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule